// File: doc/BRIEF.md
# Streaming Collective Reduction Instruction Processor

The block is one stage of a packet pipeline that carries out collective operations in hardware. Every packet on its 32-bit AXI4-Stream input starts with a 64-bit instruction. The instruction arrives as two header beats, low word first. The block carries out that instruction against the packet payload and against four internal element buffers, then sends the result out on an AXI4-Stream master port.

The instruction chooses one of five actions. The packet can be passed through, or stored in one or more buffers. It can be folded element by element with selected buffers. Selected buffers can be folded together while the packet is thrown away. A buffer can also be replayed in place of the packet. Results of the two fold actions can optionally be written back. The operators are integer sum, signed or unsigned minimum and maximum, and three bitwise and three logical operators. All of them are computed inside the block. The design accepts one element per cycle and puts every output element in a register.

Top module: `coll_insn_engine`

## Requirements
- R1: While reset is held and straight after it, `m_tvalid` is low and `s_tready` is high, ready for a header.
- R2: Header beat 0 holds the instruction: [3:0] action, [7:4] operator, [11:8] buffer mask (bit i selects buffer i), [12] write-back, [15:13] type (value 1 means signed and any other value unsigned), [31:16] element count. Header beat 1 is reserved and its contents have no effect on the output.
- R3: Action 0 (pass) forwards each payload beat unchanged, with its `tlast`. Action codes 5 to 15 behave as pass.
- R4: Action 1 (store) writes payload element k into entry k of every selected buffer and emits nothing.
- R5: Action 2 emits one element per payload beat. Each element is the payload element folded with entry k of each selected buffer, in ascending buffer order, and `tlast` comes from the payload. With write-back set, the result is also written to entry k of every selected buffer.
- R6: Action 3 emits `count` elements. Each element is entry k of the lowest selected buffer folded with the higher selected buffers, or 0 when no buffer is selected. The payload is accepted and dropped up to its `tlast`. With write-back set, the result is also written to the selected buffers.
- R7: Action 4 emits `count` elements taken from the lowest selected buffer, or zeros when the mask is empty, and drops the payload. The last emitted element carries `m_tlast`.
- R8: Operator codes: 0 sum (wrapping), 1 min, 2 max, 3 bitwise OR, 4 bitwise AND, 5 bitwise XOR, 6 logical OR, 7 logical AND, 8 logical XOR. Logical operators treat any nonzero value as 1 and return 0 or 1. Min and max follow the type field. Any other code returns the left operand.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tlast` and `m_tvalid` hold.
- R10: An output element appears on `m_tvalid` the cycle after the beat that produced it was accepted, and one element per cycle is sustained.
- R11: A buffer-only action with count 0 emits no beats. Buffer entry indices wrap modulo the buffer depth (64).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | DW (32) | Input stream data: header beats, then payload |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Last beat of the input packet |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | DW (32) | Result element |
| m_tvalid | output | 1 | Result valid |
| m_tlast | output | 1 | Last result element of the packet |
| m_tready | input | 1 | Downstream ready |

## Verification
The buffers are first loaded with a mix of signs, zeros and extreme values. Replays under different masks then show whether each store reached exactly the selected buffers. Each operator is run on that data with both type settings. This separates signed from unsigned ordering and bitwise from logical results. Buffer-only actions are given payloads longer and shorter than their count, and an empty mask and a zero count are included, so dropping, termination and `tlast` placement can be told apart. A store longer than the buffer depth shows the wrap. Throttled `m_tready` shows the hold behaviour and confirms that no element is lost or repeated.

// File: rtl/coll_insn_engine.sv
module coll_insn_engine #(
  parameter int DW    = 32,
  parameter int NBUF  = 4,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] s_tdata,
  input  logic          s_tvalid,
  input  logic          s_tlast,
  output logic          s_tready,
  output logic [DW-1:0] m_tdata,
  output logic          m_tvalid,
  output logic          m_tlast,
  input  logic          m_tready
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [1:0] S_H0 = 2'd0, S_H1 = 2'd1, S_PKT = 2'd2, S_GEN = 2'd3;
  localparam logic [3:0] A_STORE = 4'd1, A_RPKT = 4'd2, A_RBUF = 4'd3, A_REPLAY = 4'd4;

  logic [1:0]      st_q;
  logic [3:0]      op_q, alu_q;
  logic [NBUF-1:0] mask_q;
  logic            wb_q, sgn_q, gen_done_q, drop_done_q;
  logic [15:0]     cnt_q, idx_q;
  logic [DW-1:0]   rd [NBUF];
  logic [DW-1:0]   acc, rep, wr_data;
  logic            out_free, pkt_acc, gen_fire, emit, wr_en, is_gen, have;

  function automatic logic [DW-1:0] combine(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic [3:0] f, input logic sg);
    logic lt, la, lb;
    lt = sg ? ($signed(a) < $signed(b)) : (a < b);
    la = |a;
    lb = |b;
    case (f)
      4'd0: return a + b;
      4'd1: return lt ? a : b;
      4'd2: return lt ? b : a;
      4'd3: return a | b;
      4'd4: return a & b;
      4'd5: return a ^ b;
      4'd6: return {{(DW-1){1'b0}}, la | lb};
      4'd7: return {{(DW-1){1'b0}}, la & lb};
      4'd8: return {{(DW-1){1'b0}}, la ^ lb};
      default: return a;
    endcase
  endfunction

  assign is_gen   = (s_tdata[3:0] == A_RBUF) || (s_tdata[3:0] == A_REPLAY);
  assign out_free = !m_tvalid || m_tready;
  always_comb begin
    case (st_q)
      S_PKT:   s_tready = (op_q == A_STORE) || out_free;
      S_GEN:   s_tready = !drop_done_q;
      default: s_tready = 1'b1;
    endcase
  end
  assign pkt_acc  = (st_q == S_PKT) && s_tvalid && s_tready;
  assign gen_fire = (st_q == S_GEN) && !gen_done_q && out_free;
  assign emit     = (pkt_acc && op_q != A_STORE) || gen_fire;
  assign wr_en    = (pkt_acc && (op_q == A_STORE || (op_q == A_RPKT && wb_q))) ||
                    (gen_fire && op_q == A_RBUF && wb_q);
  assign wr_data  = (op_q == A_STORE) ? s_tdata : acc;

  for (genvar g = 0; g < NBUF; g++) begin : g_lane
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (wr_en && mask_q[g]) mem[idx_q[AW-1:0]] <= wr_data;
    assign rd[g] = mem[idx_q[AW-1:0]];
  end

  always_comb begin
    have = (st_q == S_PKT);
    acc  = have ? s_tdata : '0;
    for (int i = 0; i < NBUF; i++)
      if (mask_q[i]) begin
        acc  = have ? combine(acc, rd[i], alu_q, sgn_q) : rd[i];
        have = 1'b1;
      end
    rep = '0;
    for (int i = NBUF-1; i >= 0; i--)
      if (mask_q[i]) rep = rd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tlast  <= 1'b0;
    end else if (emit) begin
      m_tvalid <= 1'b1;
      m_tdata  <= (op_q == A_REPLAY) ? rep :
                  (op_q == A_RPKT || op_q == A_RBUF) ? acc : s_tdata;
      m_tlast  <= (st_q == S_PKT) ? s_tlast : (idx_q == cnt_q - 16'd1);
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_H0;
      op_q        <= '0;
      alu_q       <= '0;
      mask_q      <= '0;
      wb_q        <= 1'b0;
      sgn_q       <= 1'b0;
      cnt_q       <= '0;
      idx_q       <= '0;
      gen_done_q  <= 1'b0;
      drop_done_q <= 1'b0;
    end else begin
      case (st_q)
        S_H0: if (s_tvalid) begin
          op_q   <= s_tdata[3:0];
          alu_q  <= s_tdata[7:4];
          mask_q <= s_tdata[8 +: NBUF];
          wb_q   <= s_tdata[12];
          sgn_q  <= (s_tdata[15:13] == 3'd1);
          cnt_q  <= s_tdata[31:16];
          st_q   <= S_H1;
        end
        S_H1: if (s_tvalid) begin
          idx_q <= '0;
          if (op_q == A_RBUF || op_q == A_REPLAY) begin
            st_q        <= S_GEN;
            gen_done_q  <= (cnt_q == 16'd0);
            drop_done_q <= s_tlast;
          end else begin
            st_q <= s_tlast ? S_H0 : S_PKT;
          end
        end
        S_PKT: if (pkt_acc) begin
          idx_q <= idx_q + 16'd1;
          if (s_tlast) st_q <= S_H0;
        end
        default: begin
          if (gen_fire) begin
            idx_q <= idx_q + 16'd1;
            if (idx_q == cnt_q - 16'd1) gen_done_q <= 1'b1;
          end
          if (s_tvalid && !drop_done_q && s_tlast) drop_done_q <= 1'b1;
          if (gen_done_q && drop_done_q) st_q <= S_H0;
        end
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = is_gen;
endmodule

module coll_insn_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] m_tdata,
  input logic          m_tvalid,
  input logic          m_tlast,
  input logic          m_tready,
  input logic          s_tvalid,
  input logic          s_tready,
  input logic [1:0]    st,
  input logic [3:0]    op,
  input logic          drop_done
);
  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  a_r10_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && op != 4'd1 && s_tvalid && s_tready) |=> m_tvalid);

  a_r4_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && op == 4'd1 && !m_tvalid) |=> !m_tvalid);

  a_r6_drop_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !drop_done) |-> s_tready);

  a_r2_header_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 || st == 2'd1) |-> s_tready);
endmodule

bind coll_insn_engine coll_insn_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast),
  .m_tready(m_tready), .s_tvalid(s_tvalid), .s_tready(s_tready), .st(st_q), .op(op_q),
  .drop_done(drop_done_q));

// File: tb/coll_insn_engine_tb.sv
`timescale 1ns/1ps
module coll_insn_engine_tb;
  logic clk = 0, rst_n = 0;
  logic [31:0] s_tdata = 0;
  logic s_tvalid = 0, s_tlast = 0, s_tready;
  logic [31:0] m_tdata;
  logic m_tvalid, m_tlast, m_tready = 1;
  int checks = 0, fails = 0, cyc = 0;
  bit bp_en = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  coll_insn_engine u_dut (.clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tlast(m_tlast), .m_tready(m_tready));

  typedef struct { logic [31:0] d; logic l; } beat_t;
  beat_t expq[$];
  logic [31:0] bm [4][64];

  task automatic check(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                         input int f, input bit sg);
    longint sa, sb;
    sa = sg ? longint'(int'(a)) : longint'(a);
    sb = sg ? longint'(int'(b)) : longint'(b);
    if (f == 0) return a + b;
    if (f == 1) return (sb < sa) ? b : a;
    if (f == 2) return (sa < sb) ? b : a;
    if (f == 3) return a | b;
    if (f == 4) return a & b;
    if (f == 5) return a ^ b;
    if (f == 6) return ((a != 0) || (b != 0)) ? 1 : 0;
    if (f == 7) return ((a != 0) && (b != 0)) ? 1 : 0;
    if (f == 8) return ((a != 0) != (b != 0)) ? 1 : 0;
    return a;
  endfunction

  always @(negedge clk) begin
    cyc++;
    m_tready = bp_en ? ((cyc % 3) != 1) : 1'b1;
  end

  always begin
    @(negedge clk);
    #2;
    if (rst_n && m_tvalid && m_tready) begin
      if (expq.size() == 0) check(cur_req, 0, {31'd0, m_tlast, m_tdata}, 64'hdead);
      else begin
        beat_t e;
        e = expq.pop_front();
        check(cur_req, (m_tdata === e.d) && (m_tlast === e.l),
              {31'd0, m_tlast, m_tdata}, {31'd0, e.l, e.d});
      end
    end
  end

  task automatic put(input logic [31:0] d, input bit l);
    s_tdata = d; s_tlast = l; s_tvalid = 1;
    forever begin
      #1;
      if (s_tready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    s_tvalid = 0; s_tlast = 0;
  endtask

  task automatic run(input int op, input int f, input int mask, input bit wb, input bit sg,
                     input int cnt, input logic [31:0] pl[$]);
    logic [31:0] hdr, v;
    bit have;
    if (op == 3 || op == 4) begin
      for (int k = 0; k < cnt; k++) begin
        v = 0; have = 0;
        for (int i = 0; i < 4; i++)
          if (mask[i]) begin
            if (op == 4) begin if (!have) v = bm[i][k%64]; end
            else v = have ? ref_op(v, bm[i][k%64], f, sg) : bm[i][k%64];
            have = 1;
          end
        expq.push_back('{v, k == cnt-1});
        if (op == 3 && wb) for (int i = 0; i < 4; i++) if (mask[i]) bm[i][k%64] = v;
      end
    end else begin
      for (int k = 0; k < pl.size(); k++) begin
        if (op == 1) begin
          for (int i = 0; i < 4; i++) if (mask[i]) bm[i][k%64] = pl[k];
        end else if (op == 2) begin
          v = pl[k];
          for (int i = 0; i < 4; i++) if (mask[i]) v = ref_op(v, bm[i][k%64], f, sg);
          expq.push_back('{v, k == pl.size()-1});
          if (wb) for (int i = 0; i < 4; i++) if (mask[i]) bm[i][k%64] = v;
        end else expq.push_back('{pl[k], k == pl.size()-1});
      end
    end
    hdr = {cnt[15:0], sg ? 3'd1 : 3'd2, wb, mask[3:0], f[3:0], op[3:0]};
    @(negedge clk);
    put(hdr, 0);
    put($urandom, 0);
    for (int k = 0; k < pl.size(); k++) put(pl[k], k == pl.size()-1);
  endtask

  task automatic drain(input string req);
    for (int t = 0; t < 3000 && expq.size() != 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(req, expq.size() == 0, expq.size(), 0);
    expq.delete();
  endtask

  function automatic void mk(ref logic [31:0] q[$], input int n, input int seed);
    q.delete();
    for (int k = 0; k < n; k++)
      case ((k + seed) % 6)
        0: q.push_back(32'(k * seed + 3));
        1: q.push_back(32'hFFFF_FFF0 + 32'(k));
        2: q.push_back(0);
        3: q.push_back(32'h8000_0000);
        4: q.push_back(32'h7FFF_FFFF - 32'(seed));
        default: q.push_back(32'(seed * 17));
      endcase
  endfunction

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    check("watchdog", 0, cyc, 0);
    finish_up();
  end

  initial begin
    logic [31:0] pl[$];
    repeat (3) @(negedge clk);
    check("R1", m_tvalid === 1'b0, m_tvalid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1", (s_tready === 1'b1) && (m_tvalid === 1'b0), {s_tready, m_tvalid}, 2'b10);

    cur_req = "R3"; mk(pl, 5, 1); run(0, 0, 0, 0, 0, 0, pl); drain("R3");
    cur_req = "R3"; mk(pl, 3, 2); run(9, 0, 15, 0, 0, 0, pl); drain("R3");

    cur_req = "R4";
    mk(pl, 8, 3); run(1, 0, 1, 0, 0, 0, pl);
    mk(pl, 8, 4); run(1, 0, 2, 0, 0, 0, pl);
    mk(pl, 8, 5); run(1, 0, 12, 0, 0, 0, pl);
    drain("R4");

    cur_req = "R7"; mk(pl, 3, 6); run(4, 0, 1, 0, 0, 8, pl); drain("R7");
    cur_req = "R7"; mk(pl, 12, 7); run(4, 0, 6, 0, 0, 8, pl); drain("R7");
    cur_req = "R7"; mk(pl, 1, 8); run(4, 0, 0, 0, 0, 3, pl); drain("R7");
    cur_req = "R2"; mk(pl, 2, 9); run(4, 0, 8, 0, 0, 8, pl); drain("R2");

    for (int f = 0; f < 10; f++) begin
      cur_req = "R8"; mk(pl, 8, f + 2); run(2, (f == 9) ? 12 : f, 3, 0, 0, 0, pl); drain("R8");
      cur_req = "R8"; mk(pl, 8, f + 3); run(2, (f == 9) ? 12 : f, 3, 0, 1, 0, pl); drain("R8");
    end

    cur_req = "R5"; mk(pl, 8, 11); run(2, 0, 4, 1, 0, 0, pl); drain("R5");
    cur_req = "R5"; mk(pl, 1, 12); run(4, 0, 4, 0, 0, 8, pl); drain("R5");

    cur_req = "R6"; mk(pl, 2, 13); run(3, 2, 7, 0, 1, 8, pl); drain("R6");
    cur_req = "R6"; mk(pl, 20, 14); run(3, 5, 3, 1, 0, 6, pl); drain("R6");
    cur_req = "R6"; mk(pl, 1, 15); run(4, 0, 1, 0, 0, 8, pl); drain("R6");
    cur_req = "R6"; mk(pl, 1, 16); run(3, 1, 0, 0, 0, 2, pl); drain("R6");

    cur_req = "R11"; mk(pl, 4, 17); run(3, 0, 15, 0, 0, 0, pl); drain("R11");
    cur_req = "R11"; mk(pl, 66, 18); run(1, 0, 8, 0, 0, 0, pl);
    mk(pl, 1, 19); run(4, 0, 8, 0, 0, 2, pl); drain("R11");

    bp_en = 1;
    cur_req = "R9"; mk(pl, 30, 20); run(0, 0, 0, 0, 0, 0, pl); drain("R9");
    cur_req = "R9"; mk(pl, 16, 21); run(2, 2, 15, 1, 1, 0, pl); drain("R9");
    cur_req = "R9"; mk(pl, 3, 22); run(4, 0, 2, 0, 0, 16, pl); drain("R9");
    bp_en = 0;
    cur_req = "R10"; mk(pl, 24, 23); run(2, 0, 1, 0, 0, 0, pl); drain("R10");

    finish_up();
  end
endmodule